// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Buffered Compare

This block is a phase-correct pulse-width modulator. A counter of `WIDTH` bits climbs from zero to its maximum value TOP (all ones, 1023 at the default width), reverses, and falls back to zero. Each of these steps happens only on a clock cycle where the prescaler tick input is high. Two output channels, A and B, compare the counter against their own compare values. Each channel drives its output according to its own two-bit mode. The result is a symmetric pulse, centred on the bottom of the triangle, whose width depends on the compare value.

Software writes compare values as whole words through a simple write strobe. A write lands in a per-channel holding register. The holding register is copied into the active compare register only when the counter steps onto TOP, so a write made mid-period can never shorten or split a pulse. A read always returns the holding register, which is the value most recently written. Compare values of zero and TOP produce outputs that stay at one fixed level.

Top module: `pwm_dual_slope`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears the counter to 0 with the direction set to up, clears the holding and active compare registers of both channels to 0, and drives pwm_a, pwm_b and rd_data to 0.
- R2: The counter changes by exactly one step on each clock edge where tick is high, and keeps its value and direction on every edge where tick is low.
- R3: The counter runs 0, 1, …, TOP, TOP-1, …, 1, 0, 1, … with TOP = 2^WIDTH-1, so each endpoint lasts one step and a full period is 2·TOP steps. counting_up is 1 at count 0 and 0 at count TOP.
- R4: A write with wr_en high stores wr_data in channel A's holding register when wr_sel is 0 and in channel B's when wr_sel is 1. rd_data shows, one clock later, the holding register of the channel chosen by rd_sel (0 = A, 1 = B).
- R5: The holding value is copied to the active compare register only on the step that brings the counter to TOP; until then the output keeps following the previous active value.
- R6: While bit 1 of a channel's mode is 0 (mode 00 or 01), that channel's output is 0 on the following clock.
- R7: Mode 10 (non-inverted) with compare value v, 0 < v < TOP: the output is cleared on the step that reaches v while counting up and set on the step that reaches v while counting down, so it is high for 2·v of every 2·TOP steps.
- R8: Mode 11 (inverted) with 0 < v < TOP: the output is set on the up-counting match and cleared on the down-counting match, so it is high for 2·TOP − 2·v steps per period.
- R9: Compare value 0 gives a constant output after its next match at the bottom: low in mode 10, high in mode 11.
- R10: Compare value TOP gives a constant output after the step onto TOP: high in mode 10, low in mode 11. The up-counting and down-counting matches that meet at TOP never produce a pulse there.
- R11: The two channels are independent: each uses only its own compare registers and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaler enable; counter steps when high |
| wr_en | input | 1 | Compare write strobe |
| wr_sel | input | 1 | Write target: 0 = A, 1 = B |
| wr_data | input | WIDTH | Compare value to write |
| rd_sel | input | 1 | Read source: 0 = A, 1 = B |
| rd_data | output | WIDTH | Registered holding-register readback |
| mode_a | input | 2 | Channel A output mode |
| mode_b | input | 2 | Channel B output mode |
| pwm_a | output | 1 | Channel A PWM output (registered) |
| pwm_b | output | 1 | Channel B PWM output (registered) |
| count | output | WIDTH | Current counter value |
| counting_up | output | 1 | Counter direction, 1 = up |

## Verification
The counter, its direction and both PWM outputs change on the same tick edge. So the bench reads the output at the falling edge that follows the edge moving the counter onto a value, and pairs each output level with that counter value. rd_data trails a write or a change of rd_sel by one clock, so readback checks wait one full edge. Compare updates take effect only at the next TOP. For this reason each duty-cycle vector first waits for the counter to pass zero and then reach TOP, lets one full period settle, and then counts high samples over exactly 2·TOP ticks.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  // Output mode encoding per channel
  typedef enum logic [1:0] {
    OM_OFF_A = 2'b00,
    OM_OFF_B = 2'b01,
    OM_PLAIN = 2'b10,
    OM_INV   = 2'b11
  } out_mode_e;

  function automatic logic mode_active(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_inverted(input logic [1:0] m);
    return m[0];
  endfunction
endpackage

// File: rtl/pwm_tri_counter.sv
module pwm_tri_counter #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [WIDTH-1:0] cnt_q,
  output logic             up_q,
  output logic [WIDTH-1:0] cnt_nxt
);
  localparam logic [WIDTH-1:0] TOP  = '1;
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  always_comb begin
    cnt_nxt = up_q ? cnt_q + ONE : cnt_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ZERO;
      up_q  <= 1'b1;
    end else if (tick) begin
      cnt_q <= cnt_nxt;
      if (cnt_nxt == TOP)
        up_q <= 1'b0;
      else if (cnt_nxt == ZERO)
        up_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
  import pwm_dual_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] cnt_nxt,
  input  logic             step_up,
  output logic [WIDTH-1:0] hold_q,
  output logic             pwm_q
);
  localparam logic [WIDTH-1:0] TOP  = '1;
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] active_q;
  logic [WIDTH-1:0] cmp_eff;
  logic             at_top;
  logic             hit;
  logic             inv;

  always_comb begin
    at_top  = (cnt_nxt == TOP);
    // the step onto TOP already compares against the freshly loaded value
    cmp_eff = at_top ? hold_q : active_q;
    hit     = tick && (cnt_nxt == cmp_eff);
    inv     = mode_inverted(mode);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= ZERO;
      active_q <= ZERO;
    end else begin
      if (wr)
        hold_q <= wdata;
      if (tick && at_top)
        active_q <= hold_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= 1'b0;
    end else if (!mode_active(mode)) begin
      pwm_q <= 1'b0;
    end else if (hit) begin
      if (cmp_eff == ZERO)
        pwm_q <= inv;
      else if (cmp_eff == TOP)
        pwm_q <= ~inv;
      else
        pwm_q <= step_up ? inv : ~inv;
    end
  end
endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope #(
  parameter int WIDTH = 10,
  parameter int NCH   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_sel,
  output logic [WIDTH-1:0] rd_data,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic [WIDTH-1:0] count,
  output logic             counting_up
);
  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [WIDTH-1:0] cnt_nxt;
  logic [WIDTH-1:0] hold_v [NCH];
  logic [NCH-1:0]   pwm_v;
  logic [1:0]       mode_v [NCH];
  logic [SELW-1:0]  wsel_ix;
  logic [SELW-1:0]  rsel_ix;

  assign mode_v[0] = mode_a;
  assign mode_v[1] = mode_b;
  assign wsel_ix   = SELW'(wr_sel);
  assign rsel_ix   = SELW'(rd_sel);

  pwm_tri_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cnt_q   (count),
    .up_q    (counting_up),
    .cnt_nxt (cnt_nxt)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm_cmp_channel #(.WIDTH(WIDTH)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .wr      (wr_en && (wsel_ix == SELW'(ch))),
      .wdata   (wr_data),
      .mode    (mode_v[ch]),
      .cnt_nxt (cnt_nxt),
      .step_up (counting_up),
      .hold_q  (hold_v[ch]),
      .pwm_q   (pwm_v[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else
      rd_data <= hold_v[rsel_ix];
  end

  assign pwm_a = pwm_v[0];
  assign pwm_b = pwm_v[1];
endmodule

// File: rtl/pwm_dual_slope_chk.sv
module pwm_dual_slope_chk #(
  parameter int WIDTH = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [1:0]       mode_a,
  input logic [1:0]       mode_b,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] count,
  input logic             counting_up
);
  localparam logic [WIDTH-1:0] TOP    = '1;
  localparam logic [WIDTH-1:0] TOP_M1 = TOP - WIDTH'(1);
  localparam logic [WIDTH-1:0] ONE    = WIDTH'(1);

  // R1: reset state seen on the cycle after reset is sampled
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (count == '0) && counting_up && !pwm_a && !pwm_b && (rd_data == '0));

  // R2: one step per tick while climbing
  a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
    (tick && counting_up) |=> (count == $past(count) + ONE));

  // R2: no tick, no movement
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(count) && $stable(counting_up)));

  // R3: turn-around at TOP
  a_r3_top_turn: assert property (@(posedge clk) disable iff (rst)
    (tick && count == TOP) |=> (count == TOP_M1) && !counting_up);

  // R3: turn-around at zero
  a_r3_bottom_turn: assert property (@(posedge clk) disable iff (rst)
    (tick && count == '0) |=> (count == ONE) && counting_up);

  // R6: disconnected modes force the outputs low
  a_r6_off_a: assert property (@(posedge clk) disable iff (rst)
    !mode_a[1] |=> !pwm_a);

  a_r6_off_b: assert property (@(posedge clk) disable iff (rst)
    !mode_b[1] |=> !pwm_b);
endmodule

bind pwm_dual_slope pwm_dual_slope_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .mode_a      (mode_a),
  .mode_b      (mode_b),
  .pwm_a       (pwm_a),
  .pwm_b       (pwm_b),
  .rd_data     (rd_data),
  .count       (count),
  .counting_up (counting_up)
);

// File: tb/test_pwm_dual_slope.sv
`timescale 1ns/1ps
module test_pwm_dual_slope;
  localparam int W      = 10;
  localparam int TOPV   = (1 << W) - 1;
  localparam int PERIOD = 2 * TOPV;

  logic         clk = 1'b0;
  logic         rst, tick, wr_en, wr_sel, rd_sel;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_data;
  logic [1:0]   mode_a, mode_b;
  logic         pwm_a, pwm_b, counting_up;
  logic [W-1:0] count;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  pwm_dual_slope #(.WIDTH(W)) i_pwm_dual_slope (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .mode_a(mode_a), .mode_b(mode_b), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .count(count), .counting_up(counting_up)
  );

  typedef struct packed {
    logic [1:0]  ma;
    logic [9:0]  va;
    logic [1:0]  mb;
    logic [9:0]  vb;
    logic [11:0] exp_a;
    logic [11:0] exp_b;
  } vec_t;

  // high samples per period: mode 10 -> 2v, mode 11 -> 2046-2v, mode 0x -> 0
  localparam vec_t VECS [6] = '{
    '{2'b10, 10'd300,  2'b11, 10'd300,  12'd600,  12'd1446},  // R7 R8
    '{2'b10, 10'd0,    2'b11, 10'd0,    12'd0,    12'd2046},  // R9
    '{2'b11, 10'd1,    2'b10, 10'd1022, 12'd2044, 12'd2044},  // R8 R7 edges
    '{2'b01, 10'd512,  2'b00, 10'd700,  12'd0,    12'd0},     // R6
    '{2'b10, 10'd1,    2'b11, 10'd1022, 12'd2,    12'd2},     // R11
    '{2'b10, 10'd1023, 2'b11, 10'd1023, 12'd2046, 12'd0}      // R10
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cmp(input logic sel, input int val);
    wr_en = 1'b1; wr_sel = sel; wr_data = W'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_at(input int val, input logic up);
    for (int i = 0; i < 3 * PERIOD; i++) begin
      if (int'(count) == val && counting_up == up) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20ns * 190000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    int hi_a, hi_b;
    rst = 1'b1; tick = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    rd_sel = 1'b0; mode_a = 2'b00; mode_b = 2'b00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(count == 0 && counting_up == 1'b1, "R1 count/dir", int'(count), 0);
    check(!pwm_a && !pwm_b && rd_data == 0, "R1 outputs", int'(rd_data), 0);
    rst = 1'b0;

    // R2 no tick: no movement
    repeat (20) @(negedge clk);
    check(count == 0, "R2 idle", int'(count), 0);
    tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    check(count == 5, "R2 run", int'(count), 5);
    for (int p = 0; p < 4; p++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; repeat (2) @(negedge clk);
    end
    check(count == 9, "R2 sparse ticks", int'(count), 9);

    // R4 readback of holding registers
    write_cmp(1'b0, 123);
    write_cmp(1'b1, 456);
    rd_sel = 1'b0; @(negedge clk);
    check(rd_data == 123, "R4 read A", int'(rd_data), 123);
    rd_sel = 1'b1; @(negedge clk);
    check(rd_data == 456, "R4 read B", int'(rd_data), 456);
    rd_sel = 1'b0;

    // R3 turn-around points
    tick = 1'b1;
    wait_at(TOPV, 1'b0);
    check(count == TOPV && !counting_up, "R3 at TOP", int'(count), TOPV);
    @(negedge clk);
    check(count == TOPV - 1, "R3 after TOP", int'(count), TOPV - 1);
    wait_at(0, 1'b1);
    check(count == 0 && counting_up, "R3 at zero", int'(count), 0);
    @(negedge clk);
    check(count == 1, "R3 after zero", int'(count), 1);

    // duty-cycle vectors: R6 R7 R8 R9 R10 R11
    foreach (VECS[k]) begin
      mode_a = VECS[k].ma; mode_b = VECS[k].mb;
      write_cmp(1'b0, int'(VECS[k].va));
      write_cmp(1'b1, int'(VECS[k].vb));
      wait_at(0, 1'b1);
      wait_at(TOPV, 1'b0);
      repeat (PERIOD) @(negedge clk);
      hi_a = 0; hi_b = 0;
      for (int s = 0; s < PERIOD; s++) begin
        hi_a += int'(pwm_a); hi_b += int'(pwm_b);
        @(negedge clk);
      end
      check(hi_a == int'(VECS[k].exp_a), $sformatf("R7-R10 vec%0d A duty", k), hi_a, int'(VECS[k].exp_a));
      check(hi_b == int'(VECS[k].exp_b), $sformatf("R11 vec%0d B duty", k), hi_b, int'(VECS[k].exp_b));
    end

    // R5 buffered update: A is at TOP (constant high), write 500 mid-climb
    wait_at(100, 1'b1);
    write_cmp(1'b0, 500);
    wait_at(600, 1'b1);
    check(pwm_a == 1'b1, "R5 not applied before TOP", int'(pwm_a), 1);
    check(rd_data == 500, "R4 read newest value", int'(rd_data), 500);
    wait_at(TOPV, 1'b0);
    wait_at(400, 1'b0);
    check(pwm_a == 1'b1, "R7 high below v on descent", int'(pwm_a), 1);
    wait_at(499, 1'b1);
    check(pwm_a == 1'b1, "R7 high just before up match", int'(pwm_a), 1);
    @(negedge clk);
    check(count == 500 && pwm_a == 1'b0, "R7 cleared at up match", int'(pwm_a), 0);

    // R1 reset again mid-run
    rst = 1'b1; repeat (2) @(negedge clk);
    check(count == 0 && counting_up && !pwm_a && !pwm_b, "R1 mid-run reset", int'(count), 0);
    check(rd_data == 0, "R1 holding cleared", int'(rd_data), 0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule